// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a parallel NOR flash device. The host issues bus writes. Each write is a one-cycle strobe with a 16-bit address and a data byte. The decoder tracks those writes through a small state machine. A fixed unlock handshake must come before any mode-changing command.

The decoder has three outcomes:
- It stays in array read mode.
- It enters identification mode. There, reads return the manufacturer code, the device code or the protection status, chosen by the two lowest read address bits.
- It fires a one-cycle start pulse toward an external chip-erase sequencer.

While that sequencer reports busy, writes are locked out. The one exception is a reset byte written after the sequencer has flagged a failure. That write clears the failure and returns the decoder to read mode.

Array contents are never stored here. In read mode the byte from the external array port goes straight to the read data output.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the decoder is in read mode: `id_mode` is 0, `rd_data` equals `array_data`, and `erase_start` and `erase_abort` are 0.
- R2: When `seq_busy` is 0, a write with data F0h at any address puts the decoder in read mode. This holds from every state, including identification mode and a partly received sequence.
- R3: Three writes in a row put the decoder in identification mode (`id_mode` = 1): AAh at 5555h, then 55h at 2AAAh, then 90h at 5555h.
- R4: In identification mode, `rd_sel` = 00 makes `rd_data` C2h.
- R5: In identification mode, `rd_sel` = 01 makes `rd_data` the device code. The code is 18h when parameter TOP_BOOT is 1 and 19h when it is 0.
- R6: In identification mode, `rd_sel[1]` = 1 makes `rd_data` 01h when `rd_prot` is 1 and 00h when it is 0.
- R7: Six writes form the chip-erase command: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h. They make `erase_start` 1 for exactly the one clock cycle after the sixth strobe.
- R8: A write that does not match the next expected step of a sequence returns the decoder to read mode and issues no command. In identification mode, every write other than F0h leaves the mode unchanged.
- R9: While `seq_busy` is 1, writes change nothing. The exception is a write of F0h while `seq_fail` is 1. That write returns the decoder to read mode and makes `erase_abort` 1 for the one following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data byte |
| rd_sel | input | 2 | Two lowest bits of the read address |
| rd_prot | input | 1 | Protection status of the addressed region |
| array_data | input | 8 | Byte from the external array port |
| seq_busy | input | 1 | Erase sequencer is running |
| seq_fail | input | 1 | Erase sequencer stopped with a failure |
| rd_data | output | 8 | Read data toward the host |
| id_mode | output | 1 | Identification mode active |
| erase_start | output | 1 | One-cycle chip-erase launch pulse |
| erase_abort | output | 1 | One-cycle pulse clearing a failed erase |

## Verification
The assertions assume the following about the inputs:
- `wr_stb` carries one complete write per asserted cycle.
- `seq_fail` is meaningful only while `seq_busy` is high.
- The read-side inputs may change in any cycle, because `rd_data` is combinational.

The stimulus holds every write for exactly one strobe cycle. It raises `seq_busy` and `seq_fail` only together with a write, and drops them again before the next one, so every busy window covers whole write cycles. Random writes are biased toward correct sequence prefixes, so breaks at every step occur alongside complete commands.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int ADR_W = 16;
    localparam int DAT_W = 8;

    typedef enum logic [2:0] {
        ST_READ    = 3'd0,
        ST_UNL1    = 3'd1,
        ST_UNL2    = 3'd2,
        ST_ID      = 3'd3,
        ST_ES_SET  = 3'd4,
        ST_ES_UNL1 = 3'd5,
        ST_ES_UNL2 = 3'd6
    } cmd_state_e;

    localparam logic [DAT_W-1:0] DAT_KEY_A    = 8'hAA;
    localparam logic [DAT_W-1:0] DAT_KEY_B    = 8'h55;
    localparam logic [DAT_W-1:0] DAT_RESET    = 8'hF0;
    localparam logic [DAT_W-1:0] DAT_ID       = 8'h90;
    localparam logic [DAT_W-1:0] DAT_SETUP    = 8'h80;
    localparam logic [DAT_W-1:0] DAT_ERASE    = 8'h10;
    localparam logic [DAT_W-1:0] CODE_MFR     = 8'hC2;
    localparam logic [DAT_W-1:0] CODE_DEV_TOP = 8'h18;
    localparam logic [DAT_W-1:0] CODE_DEV_BOT = 8'h19;

    localparam logic [ADR_W-1:0] ADR_KEY_A = 16'h5555;
    localparam logic [ADR_W-1:0] ADR_KEY_B = 16'h2AAA;

    typedef struct packed {
        cmd_state_e state;
        logic       start;
        logic       abort;
    } fsm_regs_t;

endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [ADR_W-1:0] wr_addr,
    input  logic [DAT_W-1:0] wr_data,
    input  logic             seq_busy,
    input  logic             seq_fail,
    output cmd_state_e       state_o,
    output logic             erase_start,
    output logic             erase_abort
);

    fsm_regs_t regs_d, regs_q;

    function automatic logic hit(input logic [ADR_W-1:0] a, input logic [DAT_W-1:0] d,
                                 input logic [ADR_W-1:0] ea, input logic [DAT_W-1:0] ed);
        return (a == ea) && (d == ed);
    endfunction

    always_comb begin
        regs_d       = regs_q;
        regs_d.start = 1'b0;
        regs_d.abort = 1'b0;
        if (wr_stb) begin
            if (seq_busy) begin
                if (seq_fail && wr_data == DAT_RESET) begin
                    regs_d.state = ST_READ;
                    regs_d.abort = 1'b1;
                end
            end else if (wr_data == DAT_RESET) begin
                regs_d.state = ST_READ;
            end else begin
                unique case (regs_q.state)
                    ST_READ:
                        regs_d.state = hit(wr_addr, wr_data, ADR_KEY_A, DAT_KEY_A) ? ST_UNL1 : ST_READ;
                    ST_UNL1:
                        regs_d.state = hit(wr_addr, wr_data, ADR_KEY_B, DAT_KEY_B) ? ST_UNL2 : ST_READ;
                    ST_UNL2:
                        if (hit(wr_addr, wr_data, ADR_KEY_A, DAT_ID))
                            regs_d.state = ST_ID;
                        else if (hit(wr_addr, wr_data, ADR_KEY_A, DAT_SETUP))
                            regs_d.state = ST_ES_SET;
                        else
                            regs_d.state = ST_READ;
                    ST_ID:
                        regs_d.state = ST_ID;
                    ST_ES_SET:
                        regs_d.state = hit(wr_addr, wr_data, ADR_KEY_A, DAT_KEY_A) ? ST_ES_UNL1 : ST_READ;
                    ST_ES_UNL1:
                        regs_d.state = hit(wr_addr, wr_data, ADR_KEY_B, DAT_KEY_B) ? ST_ES_UNL2 : ST_READ;
                    ST_ES_UNL2: begin
                        regs_d.state = ST_READ;
                        regs_d.start = hit(wr_addr, wr_data, ADR_KEY_A, DAT_ERASE);
                    end
                    default:
                        regs_d.state = ST_READ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.state <= ST_READ;
            regs_q.start <= 1'b0;
            regs_q.abort <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state_o     = regs_q.state;
    assign erase_start = regs_q.start;
    assign erase_abort = regs_q.abort;

    assert_start_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start);

    assert_start_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> $past(wr_stb && !seq_busy && wr_data == DAT_ERASE && wr_addr == ADR_KEY_A));

    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy && !(seq_fail && wr_stb && wr_data == DAT_RESET))
        |=> (state_o == $past(state_o)) && !erase_start && !erase_abort);

    assert_abort_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        erase_abort |-> $past(seq_busy && seq_fail && wr_stb));

    assert_reset_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_data == DAT_RESET && (!seq_busy || seq_fail)) |=> state_o == ST_READ);

    assert_id_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_ID && !(wr_stb && wr_data == DAT_RESET)) |=> state_o == ST_ID);

endmodule

// File: rtl/flash_id_mux.sv
module flash_id_mux
    import flash_cmd_pkg::*;
#(
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic [1:0]       rd_sel,
    input  logic             rd_prot,
    output logic [DAT_W-1:0] id_code
);

    logic [DAT_W-1:0] dev_code;

    generate
        if (TOP_BOOT) begin : g_top
            assign dev_code = CODE_DEV_TOP;
        end else begin : g_bot
            assign dev_code = CODE_DEV_BOT;
        end
    endgenerate

    always_comb begin
        if (rd_sel[1])
            id_code = {{(DAT_W-1){1'b0}}, rd_prot};
        else if (rd_sel[0])
            id_code = dev_code;
        else
            id_code = CODE_MFR;
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_stb,
    input  logic [ADR_W-1:0]    wr_addr,
    input  logic [DAT_W-1:0]    wr_data,
    input  logic [1:0]          rd_sel,
    input  logic                rd_prot,
    input  logic [DAT_W-1:0]    array_data,
    input  logic                seq_busy,
    input  logic                seq_fail,
    output logic [DAT_W-1:0]    rd_data,
    output logic                id_mode,
    output logic                erase_start,
    output logic                erase_abort
);

    cmd_state_e       state;
    logic [DAT_W-1:0] id_code;

    flash_cmd_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (wr_stb),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .seq_busy    (seq_busy),
        .seq_fail    (seq_fail),
        .state_o     (state),
        .erase_start (erase_start),
        .erase_abort (erase_abort)
    );

    flash_id_mux #(.TOP_BOOT(TOP_BOOT)) u_id (
        .rd_sel  (rd_sel),
        .rd_prot (rd_prot),
        .id_code (id_code)
    );

    assign id_mode = (state == ST_ID);
    assign rd_data = id_mode ? id_code : array_data;

    assert_mfr_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (id_mode && rd_sel == 2'b00) |-> rd_data == CODE_MFR);

    assert_prot_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (id_mode && rd_sel[1]) |-> rd_data == {7'd0, rd_prot});

    assert_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !id_mode |-> rd_data == array_data);

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic        rd_prot = 1'b0;
    logic [7:0]  array_data = '0;
    logic        seq_busy = 1'b0;
    logic        seq_fail = 1'b0;
    logic [7:0]  rd_data;
    logic        id_mode;
    logic        erase_start;
    logic        erase_abort;

    int n_chk = 0;
    int n_bad = 0;
    int m_st  = 0;   // 0 read,1 u1,2 u2,3 id,4 setup,5 eu1,6 eu2
    bit m_start, m_abort;
    int n_erase = 0;

    always #10 clk = ~clk;

    flash_cmd_decoder #(.TOP_BOOT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_prot(rd_prot), .array_data(array_data),
        .seq_busy(seq_busy), .seq_fail(seq_fail), .rd_data(rd_data), .id_mode(id_mode),
        .erase_start(erase_start), .erase_abort(erase_abort)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int id_code(input logic [1:0] s, input logic p);
        if (s[1]) return p ? 1 : 0;
        if (s[0]) return 8'h18;
        return 8'hC2;
    endfunction

    task automatic model(input logic [15:0] a, input logic [7:0] d, input bit b, input bit f);
        m_start = 0; m_abort = 0;
        if (b) begin
            if (f && d == 8'hF0) begin m_st = 0; m_abort = 1; end
        end else if (d == 8'hF0) m_st = 0;
        else case (m_st)
            0: m_st = (a == 16'h5555 && d == 8'hAA) ? 1 : 0;
            1: m_st = (a == 16'h2AAA && d == 8'h55) ? 2 : 0;
            2: m_st = (a == 16'h5555 && d == 8'h90) ? 3 :
                      (a == 16'h5555 && d == 8'h80) ? 4 : 0;
            3: m_st = 3;
            4: m_st = (a == 16'h5555 && d == 8'hAA) ? 5 : 0;
            5: m_st = (a == 16'h2AAA && d == 8'h55) ? 6 : 0;
            default: begin
                m_start = (a == 16'h5555 && d == 8'h10);
                m_st = 0;
            end
        endcase
    endtask

    task automatic check_reads(input string req);
        for (int i = 0; i < 4; i++) begin
            logic p;
            logic [7:0] arr;
            int exp;
            p = 1'($urandom);
            arr = 8'($urandom);
            rd_sel = 2'(i);
            rd_prot = p;
            array_data = arr;
            #1;
            exp = (m_st == 3) ? id_code(2'(i), p) : int'(arr);
            check(rd_data == 8'(exp), req, rd_data, exp);
        end
        check(id_mode == (m_st == 3), req, id_mode, m_st == 3);
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d, input bit b, input bit f,
                          input string req);
        @(negedge clk);
        wr_addr = a; wr_data = d; wr_stb = 1'b1; seq_busy = b; seq_fail = f;
        model(a, d, b, f);
        @(negedge clk);
        wr_stb = 1'b0; seq_busy = 1'b0; seq_fail = 1'b0;
        if (m_start) n_erase++;
        check(erase_start == m_start, req, erase_start, m_start);
        check(erase_abort == m_abort, req, erase_abort, m_abort);
        check_reads(req);
    endtask

    task automatic id_entry(input string req);
        bus_wr(16'h5555, 8'hAA, 0, 0, req);
        bus_wr(16'h2AAA, 8'h55, 0, 0, req);
        bus_wr(16'h5555, 8'h90, 0, 0, req);
    endtask

    task automatic erase_seq(input int stop_at, input string req);
        logic [15:0] a [6];
        logic [7:0]  d [6];
        a = '{16'h5555, 16'h2AAA, 16'h5555, 16'h5555, 16'h2AAA, 16'h5555};
        d = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h10};
        for (int i = 0; i < 6; i++) begin
            if (i == stop_at) bus_wr(a[i] ^ 16'h0100, d[i], 0, 0, req);
            else bus_wr(a[i], d[i], 0, 0, req);
        end
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(erase_start == 0 && erase_abort == 0, "R1", {erase_start, erase_abort}, 0);
        check_reads("R1");

        // R3, R4, R5, R6: identification entry and codes
        id_entry("R3");
        check(id_mode == 1, "R3", id_mode, 1);
        check_reads("R4 R5 R6");
        // R8: writes in ID mode other than F0 ignored
        bus_wr(16'h5555, 8'hAA, 0, 0, "R8");
        bus_wr(16'h1234, 8'h10, 0, 0, "R8");
        check(id_mode == 1, "R8", id_mode, 1);
        // R2: F0 exits at any address
        bus_wr(16'hBEEF, 8'hF0, 0, 0, "R2");
        check(id_mode == 0, "R2", id_mode, 0);

        // R7: full erase
        erase_seq(-1, "R7");
        check(n_erase == 1, "R7", n_erase, 1);
        @(negedge clk);
        check(erase_start == 0, "R7", erase_start, 0);
        // R8: break at each step
        for (int s = 0; s < 6; s++) erase_seq(s, "R8");
        check(n_erase == 1, "R8", n_erase, 1);
        // R2: F0 mid-sequence
        bus_wr(16'h5555, 8'hAA, 0, 0, "R2");
        bus_wr(16'h2AAA, 8'h55, 0, 0, "R2");
        bus_wr(16'h0000, 8'hF0, 0, 0, "R2");
        bus_wr(16'h5555, 8'h90, 0, 0, "R2");
        check(id_mode == 0, "R2", id_mode, 0);

        // R9: busy lockout
        bus_wr(16'h5555, 8'hAA, 1, 0, "R9");
        bus_wr(16'h5555, 8'hAA, 0, 0, "R9");
        bus_wr(16'h2AAA, 8'h55, 1, 0, "R9");
        bus_wr(16'h2AAA, 8'h55, 0, 0, "R9");
        bus_wr(16'h5555, 8'h90, 0, 0, "R9");
        check(id_mode == 1, "R9", id_mode, 1);
        bus_wr(16'h0000, 8'hF0, 1, 0, "R9");
        check(id_mode == 1, "R9", id_mode, 1);
        bus_wr(16'h0000, 8'hF0, 1, 1, "R9");
        check(id_mode == 0, "R9", id_mode, 0);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] a;
            logic [7:0]  d;
            int r;
            r = int'($urandom_range(0, 99));
            case (m_st)
                0, 3, 4: begin a = 16'h5555; d = 8'hAA; end
                1, 5:    begin a = 16'h2AAA; d = 8'h55; end
                2:       begin a = 16'h5555; d = ($urandom_range(0, 1) != 0) ? 8'h90 : 8'h80; end
                default: begin a = 16'h5555; d = 8'h10; end
            endcase
            if (r < 12) a = 16'($urandom);
            else if (r < 20) d = 8'($urandom);
            else if (r < 26) d = 8'hF0;
            bus_wr(a, d, r >= 88, r >= 95, "R2 R3 R7 R8 R9");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule